// File: doc/BRIEF.md
# 4:2:2 Component Sample Demultiplexer

This block takes a single 10-bit stream of time-interleaved component video samples and rebuilds full luma/chroma triplets for three downstream converter channels. The stream repeats blue-difference chroma, luma, red-difference chroma, luma. An active-video control input sets the phase of that interleave. While it is low, the phase is parked on the chroma-blue slot. The first sample captured after it rises is always taken as chroma-blue.

Each luma sample produces one output triplet. The first luma of a group comes out with the group's own Pb and Pr. The second luma of the group reuses the same Pb and Pr. All results travel through a fixed register chain, so the first triplet of every group leaves exactly nine clocks after that group's chroma-blue sample was captured. The second triplet follows one clock later.

Top module: `comp422_demux`

## Requirements
- R1: While `rst_n` is low, `trip_vld` is 0 and `y_out`, `pb_out` and `pr_out` are all zero.
- R2: Samples captured while `vid_act` is high are read in the repeating slot order Pb (slot 0), Y (slot 1), Pr (slot 2), Y (slot 3). The first sample captured after `vid_act` goes from low to high is slot 0.
- R3: When a group's Pr sample has been captured, a triplet {Y = slot-1 sample, Pb = slot-0 sample, Pr = slot-2 sample} appears with `trip_vld` high. It appears on the clock edge 9 edges after the edge that captured the group's Pb sample.
- R4: The slot-3 luma gives a second triplet on the following edge. It carries that luma with the same Pb and Pr as the first triplet of the group.
- R5: Over an unbroken active stream, `trip_vld` is high for two edges and then low for two edges. It is never high on three edges in a row.
- R6: Dropping `vid_act` for one or more cycles at any slot, then raising it again, restarts the order at slot 0.
- R7: Samples captured while `vid_act` is low produce no triplet. Once `vid_act` has been low for 9 consecutive edges, `trip_vld` is low.
- R8: While `trip_vld` is low, the three data outputs keep the last triplet that was delivered.
- R9: A group cut short before its Pr sample is captured produces no triplet. A group cut short after its Pr but before its second luma produces only its first triplet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| vid_act | input | 1 | Active-video control; its rising edge locks the interleave phase |
| vid_din | input | 10 | Multiplexed component sample word |
| y_out | output | 10 | Luma word of the current triplet |
| pb_out | output | 10 | Blue-difference chroma word of the current triplet |
| pr_out | output | 10 | Red-difference chroma word of the current triplet |
| trip_vld | output | 1 | High for one clock per delivered triplet |

## Verification
The first triplet of a group is due 9 edges after its Pb sample is captured, which is 7 edges after its Pr. The second triplet is due 7 edges after the slot-3 luma is captured. The driver works out the capture edge of every sample as it drives it, runs its own slot model, and stamps each expected triplet with its due edge. The monitor samples on the falling edge after each rising edge and checks three things: that a triplet arrives exactly on its stamped edge, that nothing arrives without a queued expectation (R7, R9), and that the data outputs hold steady between deliveries.

// File: rtl/comp422_pkg.sv
package comp422_pkg;

  // Slot position inside one Pb/Y/Pr/Y group; the order is behaviour.
  typedef enum logic [1:0] {
    SLOT_CB  = 2'd0,
    SLOT_YA  = 2'd1,
    SLOT_CR  = 2'd2,
    SLOT_YB  = 2'd3
  } slot_e;

endpackage

// File: rtl/comp422_slot_track.sv
module comp422_slot_track
  import comp422_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic [DW-1:0] data_i,
  output logic          cap_act_o,
  output slot_e         cap_slot_o,
  output logic [DW-1:0] cap_data_o
);

  slot_e         nxt_q, nxt_d;
  slot_e         slot_q, slot_d;
  logic          act_q;
  logic [DW-1:0] data_q;
  logic          data_en;

  // Next-state: slot the following captured sample will occupy
  always_comb begin
    if (act_i) begin
      nxt_d  = slot_e'(nxt_q + 2'd1);
      slot_d = nxt_q;
    end else begin
      nxt_d  = SLOT_CB;
      slot_d = SLOT_CB;
    end
    data_en = act_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q  <= SLOT_CB;
      slot_q <= SLOT_CB;
      act_q  <= 1'b0;
      data_q <= '0;
    end else begin
      nxt_q  <= nxt_d;
      slot_q <= slot_d;
      act_q  <= act_i;
      if (data_en) begin
        data_q <= data_i;
      end
    end
  end

  assign cap_act_o  = act_q;
  assign cap_slot_o = slot_q;
  assign cap_data_o = data_q;

  AST_SLOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> (nxt_q == SLOT_CB)); // R6

  AST_LOCK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (slot_q == SLOT_CB)); // R2

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (slot_q == slot_e'($past(slot_q) + 2'd1))); // R2

endmodule

// File: rtl/comp422_group_asm.sv
module comp422_group_asm
  import comp422_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_act_i,
  input  slot_e         cap_slot_i,
  input  logic [DW-1:0] cap_data_i,
  output logic          tri_vld_o,
  output logic [DW-1:0] tri_y_o,
  output logic [DW-1:0] tri_pb_o,
  output logic [DW-1:0] tri_pr_o
);

  logic [DW-1:0] cb_hold_q, ya_hold_q, cr_hold_q;
  logic          cb_en, ya_en, cr_en;
  logic          emit_a, emit_b, emit;
  logic [DW-1:0] y_d, pb_d, pr_d;
  logic          vld_q, second_q;
  logic [DW-1:0] y_q, pb_q, pr_q;

  always_comb begin
    cb_en  = cap_act_i && (cap_slot_i == SLOT_CB);
    ya_en  = cap_act_i && (cap_slot_i == SLOT_YA);
    cr_en  = cap_act_i && (cap_slot_i == SLOT_CR);
    emit_a = cr_en;
    emit_b = cap_act_i && (cap_slot_i == SLOT_YB);
    emit   = emit_a || emit_b;
    if (emit_a) begin
      y_d  = ya_hold_q;
      pb_d = cb_hold_q;
      pr_d = cap_data_i;
    end else begin
      y_d  = cap_data_i;
      pb_d = cb_hold_q;
      pr_d = cr_hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_hold_q <= '0;
      ya_hold_q <= '0;
      cr_hold_q <= '0;
      vld_q     <= 1'b0;
      second_q  <= 1'b0;
      y_q       <= '0;
      pb_q      <= '0;
      pr_q      <= '0;
    end else begin
      if (cb_en) cb_hold_q <= cap_data_i;
      if (ya_en) ya_hold_q <= cap_data_i;
      if (cr_en) cr_hold_q <= cap_data_i;
      vld_q    <= emit;
      second_q <= emit_b;
      if (emit) begin
        y_q  <= y_d;
        pb_q <= pb_d;
        pr_q <= pr_d;
      end
    end
  end

  assign tri_vld_o = vld_q;
  assign tri_y_o   = y_q;
  assign tri_pb_o  = pb_q;
  assign tri_pr_o  = pr_q;

  AST_SECOND_FOLLOWS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && second_q) |-> ($past(vld_q) && !$past(second_q))); // R4

  AST_CHROMA_REUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && second_q) |-> (pb_q == $past(pb_q) && pr_q == $past(pr_q))); // R4

endmodule

// File: rtl/comp422_delay_line.sv
module comp422_delay_line #(
  parameter int DW    = 10,
  parameter int DEPTH = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] pb_i,
  input  logic [DW-1:0] pr_i,
  output logic          vld_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pr_o
);

  localparam int TW = 3 * DW;

  logic [TW-1:0] trip_in;
  logic [TW-1:0] trip_q [DEPTH];
  logic          vld_q  [DEPTH];

  assign trip_in = {y_i, pb_i, pr_i};

  // Each stage loads only when the item moving into it is valid, so the
  // last delivered triplet stays parked at the output between deliveries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        trip_q[i] <= '0;
        vld_q[i]  <= 1'b0;
      end
    end else begin
      vld_q[0] <= vld_i;
      if (vld_i) trip_q[0] <= trip_in;
      for (int i = 1; i < DEPTH; i++) begin
        vld_q[i] <= vld_q[i-1];
        if (vld_q[i-1]) trip_q[i] <= trip_q[i-1];
      end
    end
  end

  assign vld_o = vld_q[DEPTH-1];
  assign y_o   = trip_q[DEPTH-1][TW-1 -: DW];
  assign pb_o  = trip_q[DEPTH-1][2*DW-1 -: DW];
  assign pr_o  = trip_q[DEPTH-1][DW-1:0];

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q[DEPTH-1] |-> $stable(trip_q[DEPTH-1])); // R8

endmodule

// File: rtl/comp422_demux.sv
module comp422_demux
  import comp422_pkg::*;
#(
  parameter int DW      = 10,
  parameter int LATENCY = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vid_act,
  input  logic [DW-1:0] vid_din,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pr_out,
  output logic          trip_vld
);

  // Capture register + two more slots + assembly register come before the chain
  localparam int PRE_STAGES = 3;
  localparam int DEPTH      = LATENCY - PRE_STAGES;
  localparam int CW         = $clog2(LATENCY + 1);

  logic          cap_act;
  slot_e         cap_slot;
  logic [DW-1:0] cap_data;
  logic          asm_vld;
  logic [DW-1:0] asm_y, asm_pb, asm_pr;

  comp422_slot_track #(.DW(DW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (vid_act),
    .data_i     (vid_din),
    .cap_act_o  (cap_act),
    .cap_slot_o (cap_slot),
    .cap_data_o (cap_data)
  );

  comp422_group_asm #(.DW(DW)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_act_i  (cap_act),
    .cap_slot_i (cap_slot),
    .cap_data_i (cap_data),
    .tri_vld_o  (asm_vld),
    .tri_y_o    (asm_y),
    .tri_pb_o   (asm_pb),
    .tri_pr_o   (asm_pr)
  );

  comp422_delay_line #(.DW(DW), .DEPTH(DEPTH)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (asm_vld),
    .y_i   (asm_y),
    .pb_i  (asm_pb),
    .pr_i  (asm_pr),
    .vld_o (trip_vld),
    .y_o   (y_out),
    .pb_o  (pb_out),
    .pr_o  (pr_out)
  );

  // Checker state: consecutive edges with the active control low
  logic [CW-1:0] idle_q, idle_d;

  always_comb begin
    if (vid_act)                          idle_d = '0;
    else if (idle_q == CW'(LATENCY))      idle_d = idle_q;
    else                                  idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end

  AST_DRAINED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q == CW'(LATENCY)) |-> !trip_vld); // R7

  AST_NO_THIRD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_vld && $past(trip_vld)) |=> !trip_vld); // R5

endmodule

// File: tb/comp422_demux_bench.sv
module comp422_demux_bench;

  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vid_act;
  logic [DW-1:0] vid_din;
  logic [DW-1:0] y_out, pb_out, pr_out;
  logic          trip_vld;

  always #2 clk = ~clk;  // 250 MHz

  comp422_demux u_comp422_demux (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_act  (vid_act),
    .vid_din  (vid_din),
    .y_out    (y_out),
    .pb_out   (pb_out),
    .pr_out   (pr_out),
    .trip_vld (trip_vld)
  );

  typedef struct {
    int            due;
    logic [DW-1:0] y;
    logic [DW-1:0] pb;
    logic [DW-1:0] pr;
    string         tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  bit    mon_on = 0;

  // Bench-side slot model
  int            m_slot   = 0;
  bit            m_prev   = 0;
  logic [DW-1:0] m_pb, m_y, m_pr;
  string         first_tag = "R3";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int due, input logic [DW-1:0] y,
                      input logic [DW-1:0] pb, input logic [DW-1:0] pr,
                      input string tag);
    exp_t e;
    e.due = due; e.y = y; e.pb = pb; e.pr = pr; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Drives one sample; it is captured on edge cyc+1.
  task automatic drive(input bit a, input logic [DW-1:0] d);
    int cap_edge;
    vid_act  = a;
    vid_din  = d;
    cap_edge = cyc + 1;
    if (a) begin
      m_slot = m_prev ? (m_slot + 1) % 4 : 0;  // R2, R6: restart on rise
      case (m_slot)
        0: m_pb = d;
        1: m_y  = d;
        2: begin m_pr = d; push(cap_edge + 7, m_y, m_pb, m_pr, first_tag); end
        default: push(cap_edge + 7, d, m_pb, m_pr, "R4");
      endcase
    end
    m_prev = a;
    @(negedge clk);
  endtask

  task automatic stream(input int n, input int base);
    for (int i = 0; i < n; i++) drive(1'b1, DW'(base + 7 * i));
  endtask

  task automatic idle(input int n, input int base);
    for (int i = 0; i < n; i++) drive(1'b0, DW'(base + 3 * i));
  endtask

  // Monitor: pops expectations on their due edge
  logic [DW-1:0] last_y, last_pb, last_pr;
  bit            have_last = 0;

  always @(negedge clk) begin
    if (mon_on && !done) begin
      while (sb_q.size() > 0 && sb_q[0].due < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: triplet due at edge %0d missing (actual none, expected Y=%0d Pb=%0d Pr=%0d)",
                 sb_q[0].tag, sb_q[0].due, sb_q[0].y, sb_q[0].pb, sb_q[0].pr);
        void'(sb_q.pop_front());
      end
      if (trip_vld) begin
        n_cmp++;
        if (sb_q.size() == 0 || sb_q[0].due != cyc) begin
          n_bad++;
          $display("FAIL R7 R9: unexpected triplet at edge %0d (actual Y=%0d Pb=%0d Pr=%0d, expected none)",
                   cyc, y_out, pb_out, pr_out);
        end else begin
          if (y_out !== sb_q[0].y || pb_out !== sb_q[0].pb || pr_out !== sb_q[0].pr) begin
            n_bad++;
            $display("FAIL %s: edge %0d actual Y=%0d Pb=%0d Pr=%0d expected Y=%0d Pb=%0d Pr=%0d",
                     sb_q[0].tag, cyc, y_out, pb_out, pr_out, sb_q[0].y, sb_q[0].pb, sb_q[0].pr);
          end
          void'(sb_q.pop_front());
        end
        last_y = y_out; last_pb = pb_out; last_pr = pr_out; have_last = 1;
      end else if (have_last) begin
        n_cmp++;  // R8: outputs parked between deliveries
        if (y_out !== last_y || pb_out !== last_pb || pr_out !== last_pr) begin
          n_bad++;
          $display("FAIL R8: edge %0d actual Y=%0d Pb=%0d Pr=%0d expected Y=%0d Pb=%0d Pr=%0d",
                   cyc, y_out, pb_out, pr_out, last_y, last_pb, last_pr);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d, expected completion before 20000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n   = 1'b0;
    vid_act = 1'b0;
    vid_din = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (trip_vld !== 1'b0 || y_out !== '0 || pb_out !== '0 || pr_out !== '0) begin
      n_bad++;
      $display("FAIL R1: actual vld=%0b Y=%0d Pb=%0d Pr=%0d expected all zero",
               trip_vld, y_out, pb_out, pr_out);
    end
    rst_n  = 1'b1;
    mon_on = 1;
    idle(3, 100);

    // R2, R3, R4, R5: unbroken stream of four groups
    first_tag = "R2";
    stream(16, 5);
    first_tag = "R3";
    // R7: long idle with changing data must drain and produce nothing
    idle(12, 400);

    // R6, R9: stop after Pb,Y; restart locks to Pb again
    first_tag = "R6";
    stream(6, 600);
    idle(1, 0);
    stream(8, 700);
    // R9: stop right after Pr -> first triplet only
    first_tag = "R9";
    stream(3, 800);
    idle(1, 0);
    // R6: restart after cut at slot 3 boundary, then cut at slot 1
    first_tag = "R6";
    stream(5, 900);
    idle(2, 50);
    stream(10, 950);
    first_tag = "R3";
    idle(1, 0);
    // R5: longer run with a different data pattern
    stream(40, 20);
    idle(15, 300);

    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3: actual %0d triplets outstanding, expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule